// File: doc/BRIEF.md
# Configuration Frame Readback Sequencer

This block streams stored configuration frames out of a frame store as 128-bit packets of four 32-bit words. A readback is started in one of two ways. A write to the frame-count register scans a range of frames whose first address is the frame-address field and whose length is the written quadword count divided by the number of quadwords in one frame. A write to the single-frame register reads back exactly the one frame named in that write.

For each frame address in the range, the sequencer looks the address up in an external frame-valid bitmap. Frames that were never written produce no output and are stepped over. Each valid frame is read from an external frame memory one quadword line at a time, in ascending order, and each line leaves on a valid/ready stream as one packet. Memory reads are pipelined so that, with the consumer always ready, one packet leaves per cycle. The logic that writes frames and the bitmap sits outside this block.

Top module: `rbseq_top`

## Requirements
- R1: A trigger write (`countWrEn` or `singleWrEn`) starts a readback only when `rowConfigured`, `rowOn` and `readCfg` are all high in that cycle. Otherwise it is ignored: `busy` stays low and no packet appears.
- R2: On a `countWrEn` write, frames are visited from `rangeBase` upward, and the number of frames is `countWrData` divided by QW_PER_FRAME, rounded down. Addresses wrap modulo 2^FA_W. A count below QW_PER_FRAME gives an empty range: `busy` is high for one cycle and no packet is sent. If both trigger strobes are high in the same cycle, the count write wins.
- R3: On a `singleWrEn` write, exactly one frame is visited, at address `singleAddr`.
- R4: A frame whose `probeValid` is low while `probeAddr` names it yields no packet and no memory read. The sequencer moves to the next address.
- R5: For each valid frame F, the sequencer reads lines `memRdAddr = {F, q}` for q = 0 .. QW_PER_FRAME-1 in ascending order. Each line is sent unchanged as one packet. Word j of a packet occupies bits [32j+31:32j]. The memory returns data one cycle after `memRdEn` and holds it while `memRdEn` is low.
- R6: While `pktValid` is high and `pktReady` is low, `pktValid` stays high and `pktData` stays unchanged in the next cycle.
- R7: `busy` goes high in the cycle after an accepted trigger and stays high until the cycle after the last packet is accepted. `pktValid` is never high while `busy` is low.
- R8: Trigger writes that arrive while `busy` is high are ignored. The packet stream of the current readback is unchanged.
- R9: Asserting `rstN` low aborts any readback: `busy` and `pktValid` go low, and a later trigger runs normally.
- R10: With `pktReady` held high, a readback of P packets that skips S frames keeps `busy` high for exactly P + S + 1 cycles. One packet leaves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowConfigured | input | 1 | Row has a frame layout |
| rowOn | input | 1 | Row is powered on |
| readCfg | input | 1 | Readback mode enabled |
| rangeBase | input | FA_W | Frame-address field: start of a counted range |
| countWrEn | input | 1 | Frame-count write strobe |
| countWrData | input | CNT_W | Quadword count written |
| singleWrEn | input | 1 | Single-frame write strobe |
| singleAddr | input | FA_W | Frame address of a single-frame readback |
| probeAddr | output | FA_W | Frame address looked up in the valid bitmap |
| probeValid | input | 1 | Bitmap bit for `probeAddr` (combinational) |
| memRdEn | output | 1 | Frame memory read enable |
| memRdAddr | output | FA_W+log2(QW_PER_FRAME) | Line address {frame, quadword} |
| memRdData | input | 128 | Line read, one cycle after `memRdEn` |
| pktValid | output | 1 | Packet valid |
| pktReady | input | 1 | Packet accepted when high with `pktValid` |
| pktData | output | 128 | Packet of four words, word 0 in the low bits |
| busy | output | 1 | Readback in progress |

## Verification
The bench builds the block with FA_W = 6 and QW_PER_FRAME = 2, which gives a 64-frame store. Every start address, including the wrap from frame 63 to 0, can therefore be swept with range lengths of zero to eight frames. The sweep covers a sparse bitmap and three consumer-ready patterns, and every address is also read back as a single frame. The small frame makes the quadword-count division, the empty range and the exact busy length under full throughput cheap to reach. Gating, overlapping triggers and an aborting reset are each driven on top of this configuration.

// File: rtl/rbseq_pkg.sv
package rbseq_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seqState_t;

  typedef struct packed {
    logic loadRange;
    logic loadSingle;
    logic skipFrame;
    logic issueRead;
  } seqStrobe_t;

endpackage

// File: rtl/rbseq_ctrl.sv
module rbseq_ctrl
  import rbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       permitted,
  input  logic       countWrEn,
  input  logic       singleWrEn,
  input  logic       rangeDone,
  input  logic       probeValid,
  input  logic       outValid,
  input  logic       pktReady,
  output seqStrobe_t strobe,
  output logic       scanning
);

  seqState_t state, stateNext;
  logic      advance;
  logic      acceptTrig;

  // Output stage can take a new line when empty or being drained.
  assign advance    = !outValid || pktReady;
  assign acceptTrig = (state == SEQ_IDLE) && !outValid && permitted;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      SEQ_IDLE: begin
        if (acceptTrig && countWrEn) begin
          strobe.loadRange = 1'b1;
          stateNext        = SEQ_SCAN;
        end else if (acceptTrig && singleWrEn) begin
          strobe.loadSingle = 1'b1;
          stateNext         = SEQ_SCAN;
        end
      end
      SEQ_SCAN: begin
        if (rangeDone) begin
          stateNext = SEQ_IDLE;
        end else if (!probeValid) begin
          strobe.skipFrame = 1'b1;
        end else if (advance) begin
          strobe.issueRead = 1'b1;
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign scanning = (state == SEQ_SCAN);

endmodule

// File: rtl/rbseq_datapath.sv
module rbseq_datapath
  import rbseq_pkg::*;
#(
  parameter int FA_W         = 23,
  parameter int CNT_W        = 32,
  parameter int QW_PER_FRAME = 4,
  parameter int PKT_W        = 128,
  localparam int QW_W        = $clog2(QW_PER_FRAME),
  localparam int LINE_A_W    = FA_W + QW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic [FA_W-1:0]     rangeBase,
  input  logic [CNT_W-1:0]    countWrData,
  input  logic [FA_W-1:0]     singleAddr,
  input  logic                pktReady,
  input  logic [PKT_W-1:0]    memRdData,
  output logic [FA_W-1:0]     probeAddr,
  output logic                memRdEn,
  output logic [LINE_A_W-1:0] memRdAddr,
  output logic                outValid,
  output logic                rangeDone,
  output logic [PKT_W-1:0]    pktData
);

  logic [FA_W-1:0]  curFrame;
  logic [QW_W-1:0]  qwIdx;
  logic [CNT_W-1:0] framesLeft;
  logic             lastQw;

  assign lastQw = (qwIdx == QW_W'(QW_PER_FRAME - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curFrame   <= '0;
      qwIdx      <= '0;
      framesLeft <= '0;
    end else if (strobe.loadRange) begin
      curFrame   <= rangeBase;
      qwIdx      <= '0;
      framesLeft <= countWrData >> QW_W;
    end else if (strobe.loadSingle) begin
      curFrame   <= singleAddr;
      qwIdx      <= '0;
      framesLeft <= CNT_W'(1);
    end else if (strobe.skipFrame || (strobe.issueRead && lastQw)) begin
      curFrame   <= curFrame + FA_W'(1);
      qwIdx      <= '0;
      framesLeft <= framesLeft - CNT_W'(1);
    end else if (strobe.issueRead) begin
      qwIdx      <= qwIdx + QW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 outValid <= 1'b0;
    else if (strobe.issueRead) outValid <= 1'b1;
    else if (pktReady)         outValid <= 1'b0;
  end

  assign rangeDone = (framesLeft == '0);
  assign probeAddr = curFrame;
  assign memRdEn   = strobe.issueRead;
  assign memRdAddr = {curFrame, qwIdx};
  assign pktData   = memRdData;

endmodule

// File: rtl/rbseq_top.sv
module rbseq_top
  import rbseq_pkg::*;
#(
  parameter int FA_W         = 23,
  parameter int CNT_W        = 32,
  parameter int QW_PER_FRAME = 4,
  parameter int WORD_W       = 32,
  parameter int PKT_WORDS    = 4,
  localparam int PKT_W       = WORD_W * PKT_WORDS,
  localparam int QW_W        = $clog2(QW_PER_FRAME),
  localparam int LINE_A_W    = FA_W + QW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rowConfigured,
  input  logic                rowOn,
  input  logic                readCfg,
  input  logic [FA_W-1:0]     rangeBase,
  input  logic                countWrEn,
  input  logic [CNT_W-1:0]    countWrData,
  input  logic                singleWrEn,
  input  logic [FA_W-1:0]     singleAddr,
  output logic [FA_W-1:0]     probeAddr,
  input  logic                probeValid,
  output logic                memRdEn,
  output logic [LINE_A_W-1:0] memRdAddr,
  input  logic [PKT_W-1:0]    memRdData,
  output logic                pktValid,
  input  logic                pktReady,
  output logic [PKT_W-1:0]    pktData,
  output logic                busy
);

  seqStrobe_t strobe;
  logic       scanning;
  logic       outValid;
  logic       rangeDone;
  logic       permitted;

  assign permitted = rowConfigured && rowOn && readCfg;

  rbseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .permitted  (permitted),
    .countWrEn  (countWrEn),
    .singleWrEn (singleWrEn),
    .rangeDone  (rangeDone),
    .probeValid (probeValid),
    .outValid   (outValid),
    .pktReady   (pktReady),
    .strobe     (strobe),
    .scanning   (scanning)
  );

  rbseq_datapath #(
    .FA_W         (FA_W),
    .CNT_W        (CNT_W),
    .QW_PER_FRAME (QW_PER_FRAME),
    .PKT_W        (PKT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rangeBase   (rangeBase),
    .countWrData (countWrData),
    .singleAddr  (singleAddr),
    .pktReady    (pktReady),
    .memRdData   (memRdData),
    .probeAddr   (probeAddr),
    .memRdEn     (memRdEn),
    .memRdAddr   (memRdAddr),
    .outValid    (outValid),
    .rangeDone   (rangeDone),
    .pktData     (pktData)
  );

  assign pktValid = outValid;
  assign busy     = scanning || outValid;

endmodule

// File: rtl/rbseq_chk.sv
module rbseq_chk #(
  parameter int PKT_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             rowConfigured,
  input logic             rowOn,
  input logic             readCfg,
  input logic             probeValid,
  input logic             memRdEn,
  input logic             pktValid,
  input logic             pktReady,
  input logic [PKT_W-1:0] pktData,
  input logic             busy
);

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(rowConfigured && rowOn && readCfg));

  // R4
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> probeValid);

  // R5
  read_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (!pktValid || pktReady));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !pktValid);

  // R10
  issue_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> pktValid);

endmodule

bind rbseq_top rbseq_chk #(.PKT_W(PKT_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .rowConfigured (rowConfigured),
  .rowOn         (rowOn),
  .readCfg       (readCfg),
  .probeValid    (probeValid),
  .memRdEn       (memRdEn),
  .pktValid      (pktValid),
  .pktReady      (pktReady),
  .pktData       (pktData),
  .busy          (busy)
);

// File: tb/rbseq_top_tb_top.sv
module rbseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FA_W       = 6;
  localparam int CNT_W      = 32;
  localparam int QPF        = 2;
  localparam int QW_W       = 1;
  localparam int NFR        = 64;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              rowConfigured = 1'b1;
  logic              rowOn = 1'b1;
  logic              readCfg = 1'b1;
  logic [FA_W-1:0]   rangeBase = '0;
  logic              countWrEn = 1'b0;
  logic [CNT_W-1:0]  countWrData = '0;
  logic              singleWrEn = 1'b0;
  logic [FA_W-1:0]   singleAddr = '0;
  logic [FA_W-1:0]   probeAddr;
  logic              probeValid;
  logic              memRdEn;
  logic [FA_W:0]     memRdAddr;
  logic [127:0]      memRdData = '0;
  logic              pktValid;
  logic              pktReady = 1'b1;
  logic [127:0]      pktData;
  logic              busy;

  int nChecks = 0;
  int nFails = 0;
  int accepted = 0;
  int readyMode = 0;
  int cyc = 0;
  bit mapMode = 1'b0;
  bit inAbort = 1'b0;
  bit prevStall = 1'b0;
  logic [127:0] prevData = '0;
  logic [127:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rbseq_top #(.FA_W(FA_W), .CNT_W(CNT_W), .QW_PER_FRAME(QPF)) dut_i (
    .clk(clk), .rstN(rstN), .rowConfigured(rowConfigured), .rowOn(rowOn),
    .readCfg(readCfg), .rangeBase(rangeBase), .countWrEn(countWrEn),
    .countWrData(countWrData), .singleWrEn(singleWrEn), .singleAddr(singleAddr),
    .probeAddr(probeAddr), .probeValid(probeValid), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .pktValid(pktValid),
    .pktReady(pktReady), .pktData(pktData), .busy(busy)
  );

  function automatic bit mapValid(int f);
    return mapMode ? ((f % 5) != 3) : 1'b1;
  endfunction

  function automatic logic [127:0] lineOf(int f, int q);
    logic [127:0] l;
    for (int k = 0; k < 4; k++)
      l[32*k +: 32] = 32'hC0DE_0000 | 32'(f << 8) | 32'(q * 4 + k);
    return l;
  endfunction

  assign probeValid = mapValid(int'(probeAddr));

  // Frame memory model: one-cycle latency, holds data when idle.
  always @(posedge clk)
    if (memRdEn) memRdData <= lineOf(int'(memRdAddr >> QW_W), int'(memRdAddr[QW_W-1:0]));

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Ready pattern, updated just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (readyMode)
        0: pktReady = 1'b1;
        1: pktReady = cyc[0];
        default: pktReady = ((cyc % 3) == 0);
      endcase
    end
  end

  // Output monitor and stall stability check.
  initial begin
    forever begin
      @(negedge clk);
      if (prevStall && !inAbort)
        check(pktValid && (pktData == prevData), "R6 stalled packet held",
              pktData, prevData);
      prevStall = pktValid && !pktReady && !inAbort;
      prevData  = pktData;
      if (pktValid && pktReady) begin
        accepted++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected packet", pktData, '0);
        end else begin
          logic [127:0] e;
          e = expQ.pop_front();
          check(pktData == e, "R5 packet content/order", pktData, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  // Builds the expected stream; returns packets and skipped frames.
  task automatic buildExp(input int base, input int frames, output int pk, output int sk);
    pk = 0;
    sk = 0;
    for (int i = 0; i < frames; i++) begin
      int f;
      f = (base + i) % NFR;
      if (mapValid(f)) begin
        for (int q = 0; q < QPF; q++) expQ.push_back(lineOf(f, q));
        pk += QPF;
      end else begin
        sk++;
      end
    end
  endtask

  task automatic waitIdle(output int bc);
    bc = 0;
    while (busy && bc < 5000) begin
      bc++;
      @(negedge clk);
    end
  endtask

  task automatic runOne(input bit single, input int base, input int countVal,
                        input int rmode, input string req);
    int frames, pk, sk, bc, got0;
    readyMode = rmode;
    frames = single ? 1 : countVal / QPF;
    buildExp(base, frames, pk, sk);
    got0 = accepted;
    @(negedge clk);
    if (single) begin
      singleAddr = FA_W'(base);
      singleWrEn = 1'b1;
    end else begin
      rangeBase   = FA_W'(base);
      countWrData = CNT_W'(countVal);
      countWrEn   = 1'b1;
    end
    @(negedge clk);
    singleWrEn = 1'b0;
    countWrEn  = 1'b0;
    check(busy == 1'b1, "R7 busy after trigger", 128'(busy), 128'd1);
    waitIdle(bc);
    check(expQ.size() == 0, {req, " all expected packets sent"}, 128'(expQ.size()), 128'd0);
    check(accepted - got0 == pk, {req, " R4 packet count"}, 128'(accepted - got0), 128'(pk));
    if (rmode == 0)
      check(bc == pk + sk + 1, "R10 busy length at full rate", 128'(bc), 128'(pk + sk + 1));
    expQ.delete();
  endtask

  initial begin
    int bc, pk, sk, got0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && pktValid == 1'b0, "R9 reset state", 128'({busy, pktValid}), 128'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Dense map, full rate and stalls (R2, R5, R10).
    mapMode = 1'b0;
    for (int m = 0; m < 3; m++) begin
      runOne(1'b0, 5, 16, m, "R2");
      runOne(1'b0, 60, 9, m, "R2");
    end

    // Sweep every start address, several lengths, sparse map (R2, R4).
    mapMode = 1'b1;
    for (int b = 0; b < NFR; b++)
      for (int c = 0; c < 6; c++)
        for (int m = 0; m < 3; m++) begin
          int counts[6] = '{0, 1, 2, 4, 7, 16};
          runOne(1'b0, b, counts[c], m, "R2");
        end

    // Single-frame readback at every address (R3).
    for (int b = 0; b < NFR; b++)
      for (int m = 0; m < 2; m++)
        runOne(1'b1, b, 0, m, "R3");

    // Gating: each enable low in turn (R1).
    for (int g = 0; g < 3; g++) begin
      int bad;
      bad = 0;
      got0 = accepted;
      rowConfigured = (g != 0);
      rowOn = (g != 1);
      readCfg = (g != 2);
      @(negedge clk);
      rangeBase = 6'd1;
      countWrData = 32'd8;
      countWrEn = 1'b1;
      singleWrEn = 1'b1;
      @(negedge clk);
      countWrEn = 1'b0;
      singleWrEn = 1'b0;
      for (int i = 0; i < 6; i++) begin
        if (busy || pktValid) bad++;
        @(negedge clk);
      end
      check(bad == 0 && accepted == got0, "R1 trigger ignored without permission",
            128'(bad), 128'd0);
    end
    rowConfigured = 1'b1;
    rowOn = 1'b1;
    readCfg = 1'b1;

    // Both strobes together: count wins (R2).
    mapMode = 1'b0;
    readyMode = 0;
    buildExp(10, 3, pk, sk);
    @(negedge clk);
    rangeBase = 6'd10;
    countWrData = 32'd6;
    singleAddr = 6'd40;
    countWrEn = 1'b1;
    singleWrEn = 1'b1;
    @(negedge clk);
    countWrEn = 1'b0;
    singleWrEn = 1'b0;
    waitIdle(bc);
    check(expQ.size() == 0, "R2 count write has priority", 128'(expQ.size()), 128'd0);
    expQ.delete();

    // Triggers while busy are ignored (R8).
    readyMode = 2;
    got0 = accepted;
    buildExp(20, 4, pk, sk);
    @(negedge clk);
    rangeBase = 6'd20;
    countWrData = 32'd8;
    countWrEn = 1'b1;
    @(negedge clk);
    countWrEn = 1'b0;
    repeat (3) @(negedge clk);
    singleAddr = 6'd50;
    singleWrEn = 1'b1;
    @(negedge clk);
    singleWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rangeBase = 6'd33;
    countWrEn = 1'b1;
    @(negedge clk);
    countWrEn = 1'b0;
    waitIdle(bc);
    check(expQ.size() == 0 && accepted - got0 == pk, "R8 busy triggers ignored",
          128'(accepted - got0), 128'(pk));
    expQ.delete();

    // Reset mid-run aborts (R9).
    readyMode = 1;
    buildExp(0, 20, pk, sk);
    @(negedge clk);
    rangeBase = 6'd0;
    countWrData = 32'd40;
    countWrEn = 1'b1;
    @(negedge clk);
    countWrEn = 1'b0;
    repeat (5) @(negedge clk);
    inAbort = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && pktValid == 1'b0, "R9 reset aborts readback",
          128'({busy, pktValid}), 128'd0);
    expQ.delete();
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    inAbort = 1'b0;
    prevStall = 1'b0;
    runOne(1'b0, 7, 6, 0, "R9");

    summary();
  end

endmodule